// File: doc/BRIEF.md
# USB Endpoint Interrupt and Status Register

This block gathers the outcome of every USB transaction and a few device-level events into a two-byte interrupt register. It keeps a one-byte status record for each of six endpoints and drives an interrupt pin towards the local processor.

A protocol engine, which is outside this block, reports each finished transaction as a one-cycle pulse. The pulse carries the endpoint index, a success flag, a 4-bit error code, a setup-token flag and a DATA1 flag. Separate pulses announce bus reset, suspend change, DMA end and start of frame.

The host reads the interrupt register and the status bytes through combinational outputs. A one-cycle strobe, issued after sampling, marks each read, and that strobe applies the clear-on-read rules. The endpoint bits clear only when that endpoint's status is read. The device-event bits clear when the interrupt register itself is read.

Configuration inputs set three things:
- whether failed transactions and NAKs also interrupt;
- whether the two main-endpoint interrupts are enabled;
- how start of frame reaches the pin.

Top module: `usb_irq_status_regs`

## Requirements
- R1: Interrupt register bit i (i = 0..5) is set by a reported transaction on endpoint i. Endpoint index 0 is control OUT, 1 is control IN, 2 is endpoint 1 OUT, 3 is endpoint 1 IN, 4 is main OUT and 5 is main IN. Bit 6 is set by bus reset, bit 7 by suspend change and bit 8 (byte 2, bit 0) by DMA end. All other bits read 0.
- R2: Bits 0 to 5 are cleared only by a status read (`stat_rd`) of the matching endpoint. A read of the interrupt register or of another endpoint's status leaves them unchanged.
- R3: Bits 6, 7 and 8 are cleared by an interrupt register read (`irq_rd`).
- R4: Each transaction overwrites its endpoint's status byte with this layout: bit 0 success, bits 4:1 error code, bit 5 setup flag, bit 6 DATA1 flag, bit 7 overrun. Example codes are 0000 none, 0110 timeout, 1001 NAK and 1010 stall sent.
- R5: Bit 7 of the status byte is set when a transaction arrives while the endpoint's previous status is still unread. A status read clears bit 7 and leaves bits 6:0 unchanged.
- R6: For the IN endpoints (odd indices 1, 3 and 5) the setup flag is always stored as 0.
- R7: With `report_all` = 0, only successful transactions set endpoint interrupt bits. With `report_all` = 1, every transaction sets them. The status byte is written in both cases.
- R8: With `main_out_ie` = 0 or `main_in_ie` = 0, transactions on endpoint 4 or endpoint 5 respectively do not set their interrupt bit, but they still update the status byte.
- R9: With `sof_only` = 0 and `sof_pin_mode` = 0, `int_n` is low exactly when some interrupt register bit is 1, and start of frame has no effect on the pin.
- R10: A start-of-frame pulse leaves a pending flag that an interrupt register read clears. With `sof_only` = 0 and `sof_pin_mode` = 1, that flag also drives `int_n` low.
- R11: With `sof_only` = 1, `int_n` follows only the start-of-frame pending flag, whatever the interrupt register holds.
- R12: When a setting event and a clearing read hit the same bit in the same cycle, the bit ends up set.
- R13: After reset every interrupt bit, every status byte and the start-of-frame flag are 0, and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_valid | input | 1 | Transaction-done pulse |
| txn_ep | input | 3 | Endpoint index of the transaction |
| txn_ok | input | 1 | Transaction succeeded |
| txn_err | input | 4 | Error code of the transaction |
| txn_setup | input | 1 | Transaction carried a setup token |
| txn_data1 | input | 1 | Data packet had DATA1 PID |
| bus_rst_evt | input | 1 | Bus reset pulse |
| susp_chg_evt | input | 1 | Suspend state change pulse |
| dma_end_evt | input | 1 | DMA end pulse |
| sof_evt | input | 1 | Start-of-frame pulse |
| report_all | input | 1 | 1: all outcomes interrupt; 0: successes only |
| sof_only | input | 1 | Pin follows start of frame only |
| sof_pin_mode | input | 1 | Start of frame added to the normal pin sources |
| main_out_ie | input | 1 | Interrupt enable for endpoint 4 |
| main_in_ie | input | 1 | Interrupt enable for endpoint 5 |
| irq_rd | input | 1 | Interrupt register read strobe |
| stat_rd | input | 1 | Status byte read strobe |
| stat_rd_ep | input | 3 | Endpoint whose status is shown and read |
| irq_reg | output | 16 | Interrupt register, byte 1 in bits 7:0 |
| stat_byte | output | 8 | Status byte of `stat_rd_ep` |
| int_n | output | 1 | Interrupt pin, active low |

## Verification
A table drives transactions that differ in endpoint, success, error code, setup and DATA1 flags, and reporting mode. It separates a wrong bit-field placement from a wrong IN-side setup rule, and a success-gated interrupt from an all-outcomes one. Directed sequences then do the following:
- read the interrupt register and foreign status bytes while endpoint bits are pending, which shows whether each clear rule hits only its own bits;
- send back-to-back unread transactions to expose the overrun flag;
- walk the three pin modes with and without start of frame, which tells apart the pin-source selections;
- issue same-cycle event and read pairs, which show whether set wins over clear.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
   localparam int ERR_W   = 4;
   localparam int STAT_W  = ERR_W + 4;
   localparam int IRQ_W   = 16;
   localparam int DMA_BIT = 8;

   typedef struct packed {
      logic             overrun;
      logic             data1;
      logic             setup;
      logic [ERR_W-1:0] err;
      logic             ok;
   } txn_stat_t;

   typedef enum logic [ERR_W-1:0] {
      ERR_NONE     = 4'h0,
      ERR_PID_CHK  = 4'h1,
      ERR_PID_UNK  = 4'h2,
      ERR_UNEXP    = 4'h3,
      ERR_TOK_CRC  = 4'h4,
      ERR_DAT_CRC  = 4'h5,
      ERR_TIMEOUT  = 4'h6,
      ERR_EARLY_EOP = 4'h8,
      ERR_NAK      = 4'h9,
      ERR_STALLED  = 4'hA,
      ERR_OVERFLOW = 4'hB,
      ERR_BITSTUFF = 4'hD,
      ERR_BAD_DPID = 4'hF
   } err_code_t;

   typedef enum logic [1:0] {
      PIN_NORMAL    = 2'd0,
      PIN_SOF_ADDED = 2'd1,
      PIN_SOF_ONLY  = 2'd2
   } pin_src_t;
endpackage

// File: rtl/usb_irq_event_flag.sv
module usb_irq_event_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // set has priority over a clearing read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/usb_irq_ep_slot.sv
module usb_irq_ep_slot
   import usb_irq_pkg::*;
#(
   parameter bit IS_IN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             ok,
   input  logic [ERR_W-1:0] err,
   input  logic             setup,
   input  logic             data1,
   input  logic             report_all,
   input  logic             irq_en,
   input  logic             rd,
   output txn_stat_t        stat,
   output logic             irq
);
   logic pending;
   logic setup_eff;
   logic raise;

   generate
      if (IS_IN) begin : g_in
         assign setup_eff = 1'b0;
      end else begin : g_out
         assign setup_eff = setup;
      end
   endgenerate

   assign raise = wr & (ok | report_all) & irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat    <= '0;
         pending <= 1'b0;
      end else if (wr) begin
         stat    <= '{overrun: pending, data1: data1, setup: setup_eff,
                      err: err, ok: ok};
         pending <= 1'b1;
      end else if (rd) begin
         stat.overrun <= 1'b0;
         pending      <= 1'b0;
      end
   end

   usb_irq_event_flag i_irq_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (raise),
      .clr   (rd),
      .q     (irq)
   );
endmodule

// File: rtl/usb_irq_pin_drv.sv
module usb_irq_pin_drv
   import usb_irq_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [IRQ_W-1:0] irq_vec,
   input  logic             sof_pend,
   input  logic             sof_only,
   input  logic             sof_pin_mode,
   output logic             pin
);
   pin_src_t src;
   logic     fire;

   always_comb begin
      if (sof_only)          src = PIN_SOF_ONLY;
      else if (sof_pin_mode) src = PIN_SOF_ADDED;
      else                   src = PIN_NORMAL;
   end

   always_comb begin
      unique case (src)
         PIN_SOF_ONLY:  fire = sof_pend;
         PIN_SOF_ADDED: fire = sof_pend | (|irq_vec);
         default:       fire = |irq_vec;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pin = ~fire;
      end else begin : g_high
         assign pin = fire;
      end
   endgenerate
endmodule

// File: rtl/usb_irq_status_regs.sv
module usb_irq_status_regs
   import usb_irq_pkg::*;
#(
   parameter int  NUM_EP         = 6,
   parameter bit  PIN_ACTIVE_LOW = 1'b1,
   localparam int EP_IDX_W       = $clog2(NUM_EP)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                txn_valid,
   input  logic [EP_IDX_W-1:0] txn_ep,
   input  logic                txn_ok,
   input  logic [ERR_W-1:0]    txn_err,
   input  logic                txn_setup,
   input  logic                txn_data1,
   input  logic                bus_rst_evt,
   input  logic                susp_chg_evt,
   input  logic                dma_end_evt,
   input  logic                sof_evt,
   input  logic                report_all,
   input  logic                sof_only,
   input  logic                sof_pin_mode,
   input  logic                main_out_ie,
   input  logic                main_in_ie,
   input  logic                irq_rd,
   input  logic                stat_rd,
   input  logic [EP_IDX_W-1:0] stat_rd_ep,
   output logic [IRQ_W-1:0]    irq_reg,
   output logic [STAT_W-1:0]   stat_byte,
   output logic                int_n
);
   localparam int MAIN_OUT = NUM_EP - 2;
   localparam int MAIN_IN  = NUM_EP - 1;
   localparam int NUM_DEV  = 4;   // bus reset, suspend, dma end, sof
   localparam int DEV_RST  = 0;
   localparam int DEV_SUSP = 1;
   localparam int DEV_DMA  = 2;
   localparam int DEV_SOF  = 3;

   generate
      if (NUM_EP < 2 || NUM_EP > 6 || (NUM_EP % 2) != 0) begin : g_bad_ep
         $error("NUM_EP must be even and between 2 and 6");
      end
      if (STAT_W != 8) begin : g_bad_stat
         $error("status byte must be 8 bits wide");
      end
   endgenerate

   logic [NUM_EP-1:0]        wr_sel;
   logic [NUM_EP-1:0]        rd_sel;
   logic [NUM_EP-1:0]        ep_en;
   logic [NUM_EP-1:0]        ep_irq;
   txn_stat_t                stat_arr [NUM_EP];
   logic [NUM_EP*STAT_W-1:0] stat_flat;
   logic [NUM_DEV-1:0]       dev_set;
   logic [NUM_DEV-1:0]       dev_q;

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         assign wr_sel[i] = txn_valid && (txn_ep == EP_IDX_W'(i));
         assign rd_sel[i] = stat_rd && (stat_rd_ep == EP_IDX_W'(i));
         if (i == MAIN_OUT) begin : g_en_out
            assign ep_en[i] = main_out_ie;
         end else if (i == MAIN_IN) begin : g_en_in
            assign ep_en[i] = main_in_ie;
         end else begin : g_en_on
            assign ep_en[i] = 1'b1;
         end
         usb_irq_ep_slot #(.IS_IN((i % 2) == 1)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (wr_sel[i]),
            .ok         (txn_ok),
            .err        (txn_err),
            .setup      (txn_setup),
            .data1      (txn_data1),
            .report_all (report_all),
            .irq_en     (ep_en[i]),
            .rd         (rd_sel[i]),
            .stat       (stat_arr[i]),
            .irq        (ep_irq[i])
         );
         assign stat_flat[i*STAT_W +: STAT_W] = stat_arr[i];
      end
   endgenerate

   assign dev_set[DEV_RST]  = bus_rst_evt;
   assign dev_set[DEV_SUSP] = susp_chg_evt;
   assign dev_set[DEV_DMA]  = dma_end_evt;
   assign dev_set[DEV_SOF]  = sof_evt;

   generate
      for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
         usb_irq_event_flag i_dev_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (dev_set[d]),
            .clr   (irq_rd),
            .q     (dev_q[d])
         );
      end
   endgenerate

   always_comb begin
      irq_reg                = '0;
      irq_reg[NUM_EP-1:0]    = ep_irq;
      irq_reg[NUM_EP]        = dev_q[DEV_RST];
      irq_reg[NUM_EP+1]      = dev_q[DEV_SUSP];
      irq_reg[DMA_BIT]       = dev_q[DEV_DMA];
   end

   always_comb begin
      stat_byte = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (stat_rd_ep == EP_IDX_W'(i)) stat_byte = stat_arr[i];
      end
   end

   usb_irq_pin_drv #(.ACTIVE_LOW(PIN_ACTIVE_LOW)) i_pin (
      .irq_vec      (irq_reg),
      .sof_pend     (dev_q[DEV_SOF]),
      .sof_only     (sof_only),
      .sof_pin_mode (sof_pin_mode),
      .pin          (int_n)
   );
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
   import usb_irq_pkg::*;
#(
   parameter int  NUM_EP         = 6,
   parameter bit  PIN_ACTIVE_LOW = 1'b1,
   localparam int EP_IDX_W       = $clog2(NUM_EP)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     txn_valid,
   input logic [EP_IDX_W-1:0]      txn_ep,
   input logic                     bus_rst_evt,
   input logic                     susp_chg_evt,
   input logic                     dma_end_evt,
   input logic                     sof_only,
   input logic                     sof_pin_mode,
   input logic                     main_out_ie,
   input logic                     irq_rd,
   input logic                     stat_rd,
   input logic [IRQ_W-1:0]         irq_reg,
   input logic [NUM_EP*STAT_W-1:0] stat_flat,
   input logic                     int_n
);
   assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_evt |=> irq_reg[NUM_EP]);

   assert_dev_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rd && !bus_rst_evt && !susp_chg_evt && !dma_end_evt)
      |=> (irq_reg[IRQ_W-1:NUM_EP] == '0));

   assert_ep_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rd && !stat_rd && !txn_valid)
      |=> (irq_reg[NUM_EP-1:0] == $past(irq_reg[NUM_EP-1:0])));

   assert_in_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ep[0] && (int'(txn_ep) < NUM_EP))
      |=> !stat_flat[int'($past(txn_ep))*STAT_W + STAT_W - 3]);

   assert_main_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && (int'(txn_ep) == NUM_EP-2) && !main_out_ie && !stat_rd)
      |=> (irq_reg[NUM_EP-2] == $past(irq_reg[NUM_EP-2])));

   assert_pin_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_only && !sof_pin_mode)
      |-> ((int_n ^ PIN_ACTIVE_LOW) == (irq_reg != '0)));
endmodule

bind usb_irq_status_regs usb_irq_status_chk #(
   .NUM_EP(NUM_EP), .PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)
) i_chk (.*);

// File: tb/test_usb_irq_status_regs.sv
module test_usb_irq_status_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        txn_valid = 0, txn_ok = 0, txn_setup = 0, txn_data1 = 0;
   logic [2:0]  txn_ep = 0;
   logic [3:0]  txn_err = 0;
   logic        bus_rst_evt = 0, susp_chg_evt = 0, dma_end_evt = 0, sof_evt = 0;
   logic        report_all = 0, sof_only = 0, sof_pin_mode = 0;
   logic        main_out_ie = 1, main_in_ie = 1;
   logic        irq_rd = 0, stat_rd = 0;
   logic [2:0]  stat_rd_ep = 0;
   logic [15:0] irq_reg;
   logic [7:0]  stat_byte;
   logic        int_n;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   usb_irq_status_regs i_usb_irq_status_regs (.*);

   typedef struct packed {
      logic [2:0] ep; logic ok; logic [3:0] err; logic setup; logic data1;
      logic rpt; logic [7:0] exp_stat; logic exp_irq;
   } row_t;

   localparam row_t TBL [8] = '{
      '{3'd0, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 8'h21, 1'b1},
      '{3'd1, 1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 8'h41, 1'b1},
      '{3'd2, 1'b0, 4'h9, 1'b0, 1'b0, 1'b0, 8'h12, 1'b0},
      '{3'd2, 1'b0, 4'h9, 1'b0, 1'b0, 1'b1, 8'h12, 1'b1},
      '{3'd3, 1'b0, 4'h6, 1'b0, 1'b1, 1'b1, 8'h4C, 1'b1},
      '{3'd4, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 8'h41, 1'b1},
      '{3'd5, 1'b0, 4'hA, 1'b0, 1'b0, 1'b0, 8'h14, 1'b0},
      '{3'd5, 1'b1, 4'h0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b1}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic txn(input logic [2:0] ep, input logic ok, input logic [3:0] err,
                      input logic setup, input logic d1);
      txn_ep = ep; txn_ok = ok; txn_err = err; txn_setup = setup; txn_data1 = d1;
      txn_valid = 1;
      tick();
      txn_valid = 0;
   endtask

   task automatic read_stat(input logic [2:0] ep);
      stat_rd_ep = ep; stat_rd = 1;
      tick();
      stat_rd = 0;
   endtask

   task automatic read_irq();
      irq_rd = 1;
      tick();
      irq_rd = 0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      tick(); tick();
      // R13: reset state
      chk("R13 irq_reg", irq_reg, 16'h0);
      chk("R13 int_n", {15'b0, int_n}, 16'h1);
      chk("R13 stat", {8'h0, stat_byte}, 16'h0);
      rst_n = 1;
      tick();

      // table: R1 R4 R6 R7
      foreach (TBL[k]) begin
         report_all = TBL[k].rpt;
         txn(TBL[k].ep, TBL[k].ok, TBL[k].err, TBL[k].setup, TBL[k].data1);
         stat_rd_ep = TBL[k].ep;
         #1;
         chk($sformatf("R4/R6 row %0d stat", k), {8'h0, stat_byte}, {8'h0, TBL[k].exp_stat});
         chk($sformatf("R1/R7 row %0d irq bit", k), {15'b0, irq_reg[TBL[k].ep]},
             {15'b0, TBL[k].exp_irq});
         read_stat(TBL[k].ep);
         chk($sformatf("R2 row %0d cleared", k), irq_reg, 16'h0);
      end
      report_all = 0;

      // R2: only the own status read clears an endpoint bit
      txn(3'd0, 1, 4'h0, 0, 0);
      read_irq();
      chk("R2 kept after irq read", irq_reg, 16'h0001);
      read_stat(3'd1);
      chk("R2 kept after other stat read", irq_reg, 16'h0001);
      read_stat(3'd0);
      chk("R2 cleared by own read", irq_reg, 16'h0000);

      // R5: overrun
      txn(3'd3, 1, 4'h0, 0, 0);
      txn(3'd3, 1, 4'h0, 0, 1);
      stat_rd_ep = 3'd3; #1;
      chk("R5 overrun set", {8'h0, stat_byte}, 16'h00C1);
      read_stat(3'd3);
      chk("R5 overrun cleared", {8'h0, stat_byte}, 16'h0041);

      // R1 R3: device events
      bus_rst_evt = 1; susp_chg_evt = 1; dma_end_evt = 1;
      tick();
      bus_rst_evt = 0; susp_chg_evt = 0; dma_end_evt = 0;
      chk("R1 device bits", irq_reg, 16'h01C0);
      chk("R9 pin low", {15'b0, int_n}, 16'h0);
      read_irq();
      chk("R3 device bits cleared", irq_reg, 16'h0);
      chk("R9 pin high", {15'b0, int_n}, 16'h1);

      // R8: main endpoint masks
      main_out_ie = 0; main_in_ie = 0;
      txn(3'd4, 1, 4'h0, 0, 0);
      txn(3'd5, 1, 4'h0, 0, 0);
      chk("R8 masked bits", irq_reg, 16'h0);
      stat_rd_ep = 3'd4; #1;
      chk("R8 status still written", {8'h0, stat_byte}, 16'h0001);
      read_stat(3'd4);
      read_stat(3'd5);
      main_out_ie = 1; main_in_ie = 1;

      // R9 R10: start of frame in normal and added modes
      sof_evt = 1; tick(); sof_evt = 0;
      chk("R9 sof ignored", {15'b0, int_n}, 16'h1);
      sof_pin_mode = 1; #1;
      chk("R10 sof added", {15'b0, int_n}, 16'h0);
      chk("R10 no register bit", irq_reg, 16'h0);
      read_irq();
      chk("R10 sof cleared by read", {15'b0, int_n}, 16'h1);
      sof_pin_mode = 0;

      // R11: sof only
      sof_only = 1;
      txn(3'd0, 1, 4'h0, 0, 0);
      chk("R11 normal source ignored", {15'b0, int_n}, 16'h1);
      sof_evt = 1; tick(); sof_evt = 0;
      chk("R11 sof fires", {15'b0, int_n}, 16'h0);
      read_irq();
      chk("R11 sof cleared", {15'b0, int_n}, 16'h1);
      sof_only = 0;
      read_stat(3'd0);

      // R12: event wins over same-cycle clear
      bus_rst_evt = 1; irq_rd = 1; tick(); bus_rst_evt = 0; irq_rd = 0;
      chk("R12 device bit kept", irq_reg, 16'h0040);
      read_irq();
      txn(3'd1, 1, 4'h0, 0, 0);
      txn_ep = 3'd1; txn_ok = 1; txn_valid = 1; stat_rd_ep = 3'd1; stat_rd = 1;
      tick();
      txn_valid = 0; stat_rd = 0;
      chk("R12 endpoint bit kept", irq_reg, 16'h0002);
      read_stat(3'd1);
      chk("R12 final clear", irq_reg, 16'h0);

      done = 1;
      finish_run();
   end
endmodule